// File: doc/BRIEF.md
# Prioritised Restart Interrupt Unit

This unit sits beside a processor core's sequencer and decides whether an interrupt is taken. It watches one general-purpose request and three restart requests. A decision is made only at a permitted sampling point. Such a point is either the cycle the core marks as the second-to-last cycle of an instruction, or any cycle spent in the hold or halt state. A master enable, set and cleared by software commands, gates every acceptance. A per-input mask register can block each restart input on its own.

When an interrupt is taken, the unit clears the master enable and raises a program-counter increment inhibit that lasts until the next read strobe from the core has ended. The result of a taken restart request is an internally supplied vector. The result of a taken general request is a flag asking for an externally supplied instruction. For that request, the core's read strobe is steered to an acknowledge strobe for the length of that fetch.

Top module: `irq_arbiter`

## Requirements
- R1: Reset, which is synchronous and active high, clears the master enable, sets all three mask bits to 1 and leaves pc_inhibit, ext_fetch, vec_valid and ack_strobe low with vec_addr at 0.
- R2: An acceptance is possible only in a cycle where sample_pt, in_hold or in_halt is high. Requests present in other cycles are not taken.
- R3: The restart priority is rs_req[2] over rs_req[1] over rs_req[0]. Any live restart outranks gen_req. The vectors are 0x3C for index 2, 0x34 for index 1 and 0x2C for index 0.
- R4: A mask bit at 1 blocks the matching restart input. A mask write copies mask_data[i] into mask bit i. The new mask is first used in the cycle after the write.
- R5: rs_req[2] is edge-triggered. A rising edge sets a latch even while masked. The latch clears when index 2 is taken, or on a mask write with mask_clr_hi high. A new edge wins over a clear. rs_req[1] and rs_req[0] are level-sensitive.
- R6: sw_enable sets the master enable and sw_disable clears it. sw_disable wins when both are high. An acceptance clears the enable, and this wins over sw_enable.
- R7: The cycle after an acceptance, pc_inhibit rises. It falls the cycle after core_rd goes from high to low.
- R8: After a general request is taken, ext_fetch is high while pc_inhibit is high. During that time ack_strobe follows core_rd cycle for cycle and rd_out stays low.
- R9: After a restart request is taken, vec_valid is high with vec_addr holding its vector while pc_inhibit is high. ack_strobe stays low and rd_out follows core_rd.
- R10: No new acceptance happens while pc_inhibit is high. The stored result and the master enable are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_req | input | 1 | General-purpose interrupt request |
| rs_req | input | 3 | Restart requests; index 2 edge-triggered |
| sample_pt | input | 1 | Second-to-last instruction cycle marker |
| in_hold | input | 1 | Core is in the hold state |
| in_halt | input | 1 | Core is in the halt state |
| sw_enable | input | 1 | Software command: set master enable |
| sw_disable | input | 1 | Software command: clear master enable |
| mask_wr | input | 1 | Software command: write mask register |
| mask_data | input | 3 | Mask value; bit i at 1 blocks rs_req[i] |
| mask_clr_hi | input | 1 | With mask_wr, clears the index-2 edge latch |
| core_rd | input | 1 | Read strobe from the core |
| rd_out | output | 1 | Read strobe toward memory |
| ack_strobe | output | 1 | Interrupt acknowledge strobe |
| pc_inhibit | output | 1 | Hold the program counter for the next fetch |
| ext_fetch | output | 1 | Taken request needs an external instruction |
| vec_valid | output | 1 | Taken request has an internal vector |
| vec_addr | output | 8 | Restart vector |

## Verification
A wrong enable or mask bit only shows up at the next sampling point. It appears as a request that is taken when it should be blocked, or that is not taken when it should be. The edge latch is the hidden state that lives longest. A stale latch can make a later index-2 pick that no new edge caused. For that reason the stimulus clears the latch both by servicing it and by the mask command, and then takes a decision that exposes the result. A wrong stored result shows on vec_addr, ext_fetch or the routing of the strobe in the very next cycle. The reference model compares all of these outputs on every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
    parameter int unsigned NUM_RS   = 3;
    parameter int unsigned VEC_W    = 8;
    parameter int unsigned VEC_BASE = 8'h2C;
    parameter int unsigned VEC_STEP = 8;

    typedef struct packed {
        logic             ext;
        logic [VEC_W-1:0] vec;
    } pick_t;

    typedef struct packed {
        logic             busy;
        logic             ext;
        logic [VEC_W-1:0] vec;
    } take_t;

    function automatic logic [VEC_W-1:0] rs_vector(input int unsigned idx);
        return VEC_W'(VEC_BASE + idx * VEC_STEP);
    endfunction
endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic clr,
    output logic held
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            held   <= 1'b0;
        end else begin
            prev_q <= level;
            if (level && !prev_q)
                held <= 1'b1;
            else if (clr)
                held <= 1'b0;
        end
    end

    p_edge_caught_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(level) |=> held);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
    import irq_pkg::*;
(
    input  logic [NUM_RS-1:0] rs_live,
    input  logic              gen_live,
    output logic              any,
    output pick_t             pick,
    output logic [NUM_RS-1:0] grant
);
    always_comb begin
        grant    = '0;
        pick.ext = gen_live;
        pick.vec = '0;
        for (int i = 0; i < NUM_RS; i++) begin
            if (rs_live[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                pick.ext = 1'b0;
                pick.vec = rs_vector(i);
            end
        end
        any = (|rs_live) | gen_live;
    end

    always_comb begin
        p_one_grant_r3: assert ($onehot0(grant));
        p_rs_over_gen_r3: assert (!(pick.ext && (|grant)));
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              gen_req,
    input  logic [NUM_RS-1:0] rs_req,
    input  logic              sample_pt,
    input  logic              in_hold,
    input  logic              in_halt,
    input  logic              sw_enable,
    input  logic              sw_disable,
    input  logic              mask_wr,
    input  logic [NUM_RS-1:0] mask_data,
    input  logic              mask_clr_hi,
    input  logic              core_rd,
    output logic              rd_out,
    output logic              ack_strobe,
    output logic              pc_inhibit,
    output logic              ext_fetch,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_addr
);
    localparam int unsigned TOP = NUM_RS - 1;

    logic              en_q;
    logic [NUM_RS-1:0] mask_q;
    logic [NUM_RS-1:0] rs_src;
    logic [NUM_RS-1:0] rs_live;
    logic [NUM_RS-1:0] grant;
    logic              any;
    pick_t             pick;
    take_t             take_q;
    logic              rd_q;
    logic              sample_any;
    logic              accept;
    logic              fetch_end;
    logic              hi_clr;

    genvar g;
    generate
        for (g = 0; g < NUM_RS; g++) begin : g_src
            if (g == TOP) begin : g_edge
                irq_edge_latch u_latch (
                    .clk   (clk),
                    .rst   (rst),
                    .level (rs_req[g]),
                    .clr   (hi_clr),
                    .held  (rs_src[g])
                );
            end else begin : g_level
                assign rs_src[g] = rs_req[g];
            end
        end
    endgenerate

    assign rs_live = rs_src & ~mask_q;

    irq_prio_pick u_pick (
        .rs_live  (rs_live),
        .gen_live (gen_req),
        .any      (any),
        .pick     (pick),
        .grant    (grant)
    );

    assign sample_any = sample_pt | in_hold | in_halt;
    assign accept     = sample_any & en_q & ~take_q.busy & any;
    assign fetch_end  = rd_q & ~core_rd;
    assign hi_clr     = (accept & grant[TOP]) | (mask_wr & mask_clr_hi);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= 1'b0;
            mask_q <= '1;
            take_q <= '0;
            rd_q   <= 1'b0;
        end else begin
            rd_q <= core_rd;
            if (accept)
                en_q <= 1'b0;
            else if (sw_disable)
                en_q <= 1'b0;
            else if (sw_enable)
                en_q <= 1'b1;
            if (mask_wr)
                mask_q <= mask_data;
            if (accept) begin
                take_q.busy <= 1'b1;
                take_q.ext  <= pick.ext;
                take_q.vec  <= pick.vec;
            end else if (fetch_end) begin
                take_q <= '0;
            end
        end
    end

    assign pc_inhibit = take_q.busy;
    assign ext_fetch  = take_q.busy & take_q.ext;
    assign vec_valid  = take_q.busy & ~take_q.ext;
    assign vec_addr   = vec_valid ? take_q.vec : '0;
    assign ack_strobe = core_rd & ext_fetch;
    assign rd_out     = core_rd & ~ext_fetch;

    p_no_take_outside_r2: assert property (@(posedge clk) disable iff (rst)
        !sample_any |=> !$rose(pc_inhibit));
    p_mask_load_r4: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> mask_q == $past(mask_data));
    p_accept_clears_en_r6: assert property (@(posedge clk) disable iff (rst)
        accept |=> !en_q);
    p_strobe_split_r8: assert property (@(posedge clk) disable iff (rst)
        !(ack_strobe && rd_out));
    p_result_kind_r9: assert property (@(posedge clk) disable iff (rst)
        !(vec_valid && ext_fetch));
    p_busy_holds_r10: assert property (@(posedge clk) disable iff (rst)
        (pc_inhibit && !fetch_end) |=> (pc_inhibit && $stable(vec_addr) && $stable(ext_fetch)));
    p_inhibit_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (pc_inhibit && fetch_end) |=> !pc_inhibit);
endmodule

// File: tb/test_irq_arbiter.sv
`timescale 1ns/1ps
module test_irq_arbiter;
    logic clk = 0;
    logic rst = 1;
    logic gen_req = 0;
    logic [2:0] rs_req = '0;
    logic sample_pt = 0, in_hold = 0, in_halt = 0;
    logic sw_enable = 0, sw_disable = 0, mask_wr = 0, mask_clr_hi = 0;
    logic [2:0] mask_data = '0;
    logic core_rd = 0;
    logic rd_out, ack_strobe, pc_inhibit, ext_fetch, vec_valid;
    logic [7:0] vec_addr;

    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_arbiter i_irq_arbiter (
        .clk(clk), .rst(rst), .gen_req(gen_req), .rs_req(rs_req),
        .sample_pt(sample_pt), .in_hold(in_hold), .in_halt(in_halt),
        .sw_enable(sw_enable), .sw_disable(sw_disable), .mask_wr(mask_wr),
        .mask_data(mask_data), .mask_clr_hi(mask_clr_hi), .core_rd(core_rd),
        .rd_out(rd_out), .ack_strobe(ack_strobe), .pc_inhibit(pc_inhibit),
        .ext_fetch(ext_fetch), .vec_valid(vec_valid), .vec_addr(vec_addr)
    );

    // behavioural reference model
    bit m_en, m_latch, m_prev2, m_busy, m_ext, m_rdq;
    bit [2:0] m_mask;
    int m_vec;
    bit s_samp, s_acc, s_pick2, s_ext, s_r2, s_r1, s_r0;
    int s_vec;

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_mask = 3'b111; m_latch = 0; m_prev2 = 0;
            m_busy = 0; m_ext = 0; m_vec = 0; m_rdq = 0;
        end else begin
            s_samp = sample_pt || in_hold || in_halt;
            s_r2 = m_latch && !m_mask[2];
            s_r1 = rs_req[1] && !m_mask[1];
            s_r0 = rs_req[0] && !m_mask[0];
            s_pick2 = 0; s_ext = 0; s_vec = 0;
            if (s_r2) begin s_vec = 60; s_pick2 = 1; end
            else if (s_r1) s_vec = 52;
            else if (s_r0) s_vec = 44;
            else s_ext = 1;
            s_acc = s_samp && m_en && !m_busy && (s_r2 || s_r1 || s_r0 || gen_req);
            if (rs_req[2] && !m_prev2) m_latch = 1;
            else if ((s_acc && s_pick2) || (mask_wr && mask_clr_hi)) m_latch = 0;
            m_prev2 = rs_req[2];
            if (s_acc) m_en = 0;
            else if (sw_disable) m_en = 0;
            else if (sw_enable) m_en = 1;
            if (mask_wr) m_mask = mask_data;
            if (s_acc) begin m_busy = 1; m_ext = s_ext; m_vec = s_ext ? 0 : s_vec; end
            else if (m_rdq && !core_rd) begin m_busy = 0; m_ext = 0; m_vec = 0; end
            m_rdq = core_rd;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (!rst && !done) begin
            chk("R7 pc_inhibit", pc_inhibit, m_busy);
            chk("R8 ext_fetch", ext_fetch, m_busy && m_ext);
            chk("R8 ack_strobe", ack_strobe, core_rd && m_busy && m_ext);
            chk("R9 rd_out", rd_out, core_rd && !(m_busy && m_ext));
            chk("R9 vec_valid", vec_valid, m_busy && !m_ext);
            chk("R3 vec_addr", vec_addr, (m_busy && !m_ext) ? m_vec : 0);
        end
    end

    task automatic pulse_sample();
        @(negedge clk) sample_pt = 1;
        @(negedge clk) sample_pt = 0;
        #2;
    endtask

    task automatic enable();
        @(negedge clk) sw_enable = 1;
        @(negedge clk) sw_enable = 0;
    endtask

    task automatic fetch(input bit want_ack);
        @(negedge clk) core_rd = 1;
        #2;
        chk("R8 ack during fetch", ack_strobe, want_ack);
        chk("R9 rd during fetch", rd_out, !want_ack);
        @(negedge clk);
        @(negedge clk) core_rd = 0;
        #2;
        chk("R7 inhibit held to strobe end", pc_inhibit, 1);
        @(negedge clk);
        #2;
        chk("R7 inhibit released", pc_inhibit, 0);
    endtask

    task automatic write_mask(input logic [2:0] v, input bit clr);
        @(negedge clk) begin mask_wr = 1; mask_data = v; mask_clr_hi = clr; end
        @(negedge clk) begin mask_wr = 0; mask_clr_hi = 0; end
    endtask

    initial begin
        #(20 * 50000);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #2;
        chk("R1 pc_inhibit after reset", pc_inhibit, 0);
        chk("R1 vec_addr after reset", vec_addr, 0);
        chk("R1 ack after reset", ack_strobe, 0);

        // enable cleared by reset: sample with a request, nothing taken
        gen_req = 1;
        pulse_sample();
        chk("R1 enable clear after reset", pc_inhibit, 0);

        enable();
        rs_req[1] = 1;
        repeat (3) @(negedge clk);
        #2;
        chk("R2 no sample no take", pc_inhibit, 0);
        pulse_sample();
        chk("R1 masks set by reset -> general taken", ext_fetch, 1);
        chk("R1 no vector", vec_valid, 0);
        fetch(1);

        pulse_sample();
        chk("R6 auto disable", pc_inhibit, 0);

        write_mask(3'b000, 1);
        enable();
        rs_req[0] = 1;
        pulse_sample();
        chk("R3 rs1 over rs0 and gen", vec_addr, 8'h34);
        fetch(0);

        @(negedge clk) rs_req[2] = 1;
        enable();
        pulse_sample();
        chk("R5 edge taken top vector", vec_addr, 8'h3C);
        fetch(0);
        enable();
        pulse_sample();
        chk("R5 latch cleared by service", vec_addr, 8'h34);

        enable();
        pulse_sample();
        chk("R10 busy keeps result", vec_addr, 8'h34);
        chk("R10 still inhibited", pc_inhibit, 1);
        fetch(0);

        write_mask(3'b010, 0);
        pulse_sample();
        chk("R4 masked rs1 skipped", vec_addr, 8'h2C);
        fetch(0);

        enable();
        @(negedge clk) begin mask_wr = 1; mask_data = 3'b001; sample_pt = 1; end
        @(negedge clk) begin mask_wr = 0; sample_pt = 0; end
        #2;
        chk("R4 old mask used in write cycle", vec_addr, 8'h2C);
        fetch(0);

        enable();
        @(negedge clk) in_hold = 1;
        @(negedge clk) in_hold = 0;
        #2;
        chk("R2 hold sampling", vec_addr, 8'h34);
        fetch(0);

        @(negedge clk) begin sw_enable = 1; sw_disable = 1; end
        @(negedge clk) begin sw_enable = 0; sw_disable = 0; end
        pulse_sample();
        chk("R6 disable wins", pc_inhibit, 0);

        rs_req = 3'b000;
        enable();
        @(negedge clk) in_halt = 1;
        @(negedge clk) in_halt = 0;
        #2;
        chk("R2 halt sampling general", ext_fetch, 1);
        fetch(1);

        gen_req = 0;
        write_mask(3'b000, 0);
        @(negedge clk) rs_req[2] = 1;
        write_mask(3'b000, 1);
        enable();
        pulse_sample();
        chk("R5 latch cleared by mask command", pc_inhibit, 0);

        repeat (2) @(negedge clk);
        #2;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule